// File: doc/BRIEF.md
# Two-step watchdog refresh controller

This block is the watchdog of a small 8-bit microcontroller together with the two special-function registers that control it. The CPU reaches it over a simple register write bus: a write strobe, an 8-bit address and an 8-bit data byte. Reads use the same address and return data combinationally. Each register also holds interrupt enable bits, and one of them carries the global interrupt enable. The block stores these bits and exposes the global enable as a pin. The interrupt controller that uses the other enable bits lies outside this block.

Software starts the watchdog by setting a trigger bit. To keep a running watchdog from firing, software must perform a two-step sequence. It first sets an arm bit in one register. Its very next register write must then set the trigger bit in the other register. Both bits are flags that clear themselves: each stays set for a fixed number of clocks (12 by default) and then drops. A lone trigger, a trigger that follows some other write, or a trigger that arrives after the arm flag has dropped does not reload the counter.

Once started, the watchdog is a down-counter loaded with a parameterised reload value. If it reaches zero without a valid refresh, the block raises a one-cycle reset request and stops. Software writes cannot stop it; only a system reset or an expiry does.

Top module: `wdr_top`

## Requirements
- R1: After reset, reads of address 0xA8 and 0xB8 return 0x00, and `gie_o`, `wd_active_o`, `reset_req_o` and `wd_count_o` are all 0.
- R2: At address 0xA8, bits 7 and 4..0 store the written value and bit 5 reads 0. `gie_o` follows bit 7 of 0xA8. At address 0xB8, bits 5..1 store the written value, and bits 7 and 0 read 0. Any other address reads 0x00, and writes to it change neither register.
- R3: Writing 1 to bit 6 of 0xA8 (arm flag) sets that flag. It reads 1 for exactly 12 cycles after the write edge and 0 from the 12th following edge on. Writing 0 to bit 6 does not clear the flag. Writing 1 again while it is set restarts the 12-cycle hold.
- R4: Writing 1 to bit 6 of 0xB8 (trigger flag) sets that flag. It reads 1 for exactly 12 cycles after the write edge and then clears itself.
- R5: A trigger write while the watchdog is inactive activates it, with `wd_count_o` equal to the reload value (200 by default) right after the write edge. This also holds after an earlier expiry.
- R6: When the watchdog is active, a trigger write refreshes it (reloads the count) only if three conditions hold. The trigger write must be the next bus write after a write of 0xA8 with bit 6 set. That arming write must itself have had bit 6 set. The arm flag must still be set when the trigger write occurs.
- R7: A trigger write without the arm write just before it does not reload the count. Neither does a trigger after an intervening write to any address, including 0xA8 with bit 6 at 0, nor a trigger after the arm flag has cleared.
- R8: While active, the count decreases by one per clock. On the edge after the count reads 0, `reset_req_o` goes high for exactly one cycle and `wd_active_o` goes low.
- R9: A valid refresh on the same edge that would expire the watchdog (count 0) takes priority. The count reloads, the watchdog stays active, and no reset request is raised.
- R10: Register writes can never deactivate a running watchdog. Clearing the enables or writing 0 to either bit 6 leaves it active and counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sfr_we_i | input | 1 | Register write strobe, one write per cycle it is high |
| sfr_addr_i | input | 8 | Register address for writes and reads |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for `sfr_addr_i`, combinational |
| gie_o | output | 1 | Global interrupt enable (bit 7 of 0xA8) |
| wd_active_o | output | 1 | Watchdog running |
| wd_count_o | output | 16 | Current watchdog count |
| reset_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
Refresh and expiry can land on the same clock edge. That happens when a valid arm-then-trigger pair is timed so that the trigger write hits the edge on which the count stands at 0. The bench provokes it by starting the watchdog and waiting until the count is one short of zero. It then issues the arm write and checks that the count reads 0 while the watchdog is still active. Finally it issues the trigger write and judges that the count equals the reload value, the watchdog is still active, and the reset request stays low on that cycle and the next.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  localparam int unsigned SFR_W = 8;
  typedef logic [SFR_W-1:0] sfr_byte_t;

  // bit positions that software depends on
  localparam int unsigned GIE_BIT  = 7;
  localparam int unsigned ARM_BIT  = 6;
  localparam int unsigned TRIG_BIT = 6;

  // plainly stored bits of each register (self-clearing bit 6 excluded)
  localparam sfr_byte_t KEEP_MASK_A = 8'h9F;
  localparam sfr_byte_t KEEP_MASK_B = 8'h3E;

  localparam int unsigned N_FLAGS = 2;
  localparam int unsigned FLAG_ARM  = 0;
  localparam int unsigned FLAG_TRIG = 1;
endpackage

// File: rtl/wdr_rst_sync.sv
module wdr_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/wdr_selfclr.sv
module wdr_selfclr #(
  parameter int unsigned HOLD = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic flag_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  localparam logic [CW-1:0] ONE_V  = CW'(1);

  logic          flag_q, flag_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd_en;

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (set_i) begin
      flag_d = 1'b1;
      cnt_d  = HOLD_V;
    end else if (flag_q) begin
      if (cnt_q == ONE_V) begin
        flag_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - ONE_V;
      end
    end
  end

  assign upd_en = set_i | flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wdr_regfile.sv
module wdr_regfile
  import wdr_pkg::*;
#(
  parameter sfr_byte_t ADDR_A = 8'hA8,
  parameter sfr_byte_t ADDR_B = 8'hB8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  sfr_byte_t addr_i,
  input  sfr_byte_t wdata_i,
  input  logic      arm_flag_i,
  input  logic      trig_flag_i,
  output sfr_byte_t rdata_o,
  output logic      gie_o,
  output logic      arm_wr_o,
  output logic      trig_wr_o
);
  sfr_byte_t reg_a_q, reg_a_d;
  sfr_byte_t reg_b_q, reg_b_d;
  logic      hit_a, hit_b;

  assign hit_a = we_i && (addr_i == ADDR_A);
  assign hit_b = we_i && (addr_i == ADDR_B);

  always_comb begin
    reg_a_d = wdata_i & KEEP_MASK_A;
    reg_b_d = wdata_i & KEEP_MASK_B;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_a_q <= '0;
    end else if (hit_a) begin
      reg_a_q <= reg_a_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_b_q <= '0;
    end else if (hit_b) begin
      reg_b_q <= reg_b_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_A) begin
      rdata_o = reg_a_q;
      rdata_o[ARM_BIT] = arm_flag_i;
    end else if (addr_i == ADDR_B) begin
      rdata_o = reg_b_q;
      rdata_o[TRIG_BIT] = trig_flag_i;
    end
  end

  assign gie_o     = reg_a_q[GIE_BIT];
  assign arm_wr_o  = hit_a && wdata_i[ARM_BIT];
  assign trig_wr_o = hit_b && wdata_i[TRIG_BIT];
endmodule

// File: rtl/wdr_counter.sv
module wdr_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RELOAD = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             reload_i,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] RELOAD_V = RELOAD[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             load, cnt_en;

  assign load   = start_i | reload_i;
  assign cnt_en = load | active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    req_d    = 1'b0;
    if (load) begin
      active_d = 1'b1;
      cnt_d    = RELOAD_V;
    end else if (active_q) begin
      if (cnt_q == '0) begin
        active_d = 1'b0;
        req_d    = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE_V;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (cnt_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign active_o = active_q;
  assign count_o  = cnt_q;
  assign expire_o = req_q;
endmodule

// File: rtl/wdr_top.sv
module wdr_top
  import wdr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RELOAD = 200,
  parameter int unsigned HOLD   = 12,
  parameter sfr_byte_t   ADDR_A = 8'hA8,
  parameter sfr_byte_t   ADDR_B = 8'hB8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sfr_we_i,
  input  logic [7:0]       sfr_addr_i,
  input  logic [7:0]       sfr_wdata_i,
  output logic [7:0]       sfr_rdata_o,
  output logic             gie_o,
  output logic             wd_active_o,
  output logic [CNT_W-1:0] wd_count_o,
  output logic             reset_req_o
);
  logic               rst_n_int;
  logic               arm_wr, trig_wr;
  logic [N_FLAGS-1:0] flag_set, flag_val;
  logic               arm_follow_q, arm_follow_d;
  logic               start_w, refresh_w;
  logic               active;

  wdr_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  wdr_regfile #(
    .ADDR_A (ADDR_A),
    .ADDR_B (ADDR_B)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .we_i        (sfr_we_i),
    .addr_i      (sfr_addr_i),
    .wdata_i     (sfr_wdata_i),
    .arm_flag_i  (flag_val[FLAG_ARM]),
    .trig_flag_i (flag_val[FLAG_TRIG]),
    .rdata_o     (sfr_rdata_o),
    .gie_o       (gie_o),
    .arm_wr_o    (arm_wr),
    .trig_wr_o   (trig_wr)
  );

  assign flag_set[FLAG_ARM]  = arm_wr;
  assign flag_set[FLAG_TRIG] = trig_wr;

  for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
    wdr_selfclr #(
      .HOLD (HOLD)
    ) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .set_i  (flag_set[gi]),
      .flag_o (flag_val[gi])
    );
  end

  // sequence tracker: remembers whether the latest bus write was an arming write
  always_comb begin
    arm_follow_d = arm_wr;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      arm_follow_q <= 1'b0;
    end else if (sfr_we_i) begin
      arm_follow_q <= arm_follow_d;
    end
  end

  assign start_w   = trig_wr && !active;
  assign refresh_w = trig_wr && active && arm_follow_q && flag_val[FLAG_ARM];

  wdr_counter #(
    .CNT_W  (CNT_W),
    .RELOAD (RELOAD)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .start_i  (start_w),
    .reload_i (refresh_w),
    .active_o (active),
    .count_o  (wd_count_o),
    .expire_o (reset_req_o)
  );

  assign wd_active_o = active;
endmodule

// File: rtl/wdr_chk.sv
module wdr_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned RELOAD = 200,
  parameter logic [7:0]  ADDR_A = 8'hA8,
  parameter logic [7:0]  ADDR_B = 8'hB8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic [7:0]       addr,
  input logic [7:0]       wdata,
  input logic             arm_flag,
  input logic             trig_flag,
  input logic             refresh,
  input logic             active,
  input logic [CNT_W-1:0] count,
  input logic             reset_req
);
  localparam logic [CNT_W-1:0] RELOAD_V = RELOAD[CNT_W-1:0];

  // R3: an arming write leaves the arm flag set
  a_r3_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_A && wdata[6]) |=> arm_flag);

  // R4: a trigger write leaves the trigger flag set
  a_r4_trig_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_B && wdata[6]) |=> trig_flag);

  // R5: trigger while idle starts with the reload value
  a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_B && wdata[6] && !active) |=> (active && count == RELOAD_V));

  // R6: a qualified refresh reloads
  a_r6_refresh_loads: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (active && count == RELOAD_V));

  // R7: without a refresh the running count only steps down
  a_r7_no_stray_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !refresh && count != '0) |=> (count == $past(count) - 1'b1));

  // R8: zero count without refresh expires
  a_r8_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count == '0 && !refresh) |=> (reset_req && !active));

  // R8: the request lasts one cycle
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  // R9: refresh at zero gives no request
  a_r9_refresh_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count == '0 && refresh) |=> (!reset_req && active));

  // R10: nonzero count keeps the watchdog running
  a_r10_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count != '0) |=> active);
endmodule

bind wdr_top wdr_chk #(
  .CNT_W  (CNT_W),
  .RELOAD (RELOAD),
  .ADDR_A (ADDR_A),
  .ADDR_B (ADDR_B)
) u_chk (
  .clk       (clk_i),
  .rst_n     (rst_n_int),
  .we        (sfr_we_i),
  .addr      (sfr_addr_i),
  .wdata     (sfr_wdata_i),
  .arm_flag  (flag_val[0]),
  .trig_flag (flag_val[1]),
  .refresh   (refresh_w),
  .active    (wd_active_o),
  .count     (wd_count_o),
  .reset_req (reset_req_o)
);

// File: tb/sim_wdr_top.sv
module sim_wdr_top;
  localparam int CLK_PERIOD = 10;
  localparam int RLD  = 200;
  localparam logic [7:0] RA = 8'hA8;
  localparam logic [7:0] RB = 8'hB8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [7:0]  addr, wdata, rdata;
  logic        gie, active, req;
  logic [15:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdr_top u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .sfr_we_i    (we),
    .sfr_addr_i  (addr),
    .sfr_wdata_i (wdata),
    .sfr_rdata_o (rdata),
    .gie_o       (gie),
    .wd_active_o (active),
    .wd_count_o  (count),
    .reset_req_o (req)
  );

  task automatic check(input string req_tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(RA, v); check("R1", "reg A", v, 8'h00);
    rd(RB, v); check("R1", "reg B", v, 8'h00);
    check("R1", "gie", gie, 0);
    check("R1", "active", active, 0);
    check("R1", "reset_req", req, 0);
    check("R1", "count", count, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    do_reset();
    wr(RA, 8'hBF);
    rd(RA, v); check("R2", "reg A stored bits", v, 8'h9F);
    check("R2", "gie follows bit7", gie, 1);
    wr(RB, 8'hBF);
    rd(RB, v); check("R2", "reg B stored bits", v, 8'h3E);
    check("R2", "no start from bit6=0", active, 0);
    wr(8'h55, 8'hFF);
    rd(8'h55, v); check("R2", "other address", v, 8'h00);
    rd(RA, v); check("R2", "reg A untouched", v, 8'h9F);
    rd(RB, v); check("R2", "reg B untouched", v, 8'h3E);
  endtask

  task automatic t_arm_flag();
    logic [7:0] v;
    do_reset();
    wr(RA, 8'h40);
    rd(RA, v); check("R3", "arm set", v, 8'h40);
    idle(11);
    rd(RA, v); check("R3", "arm at 12th cycle", v, 8'h40);
    idle(1);
    rd(RA, v); check("R3", "arm cleared", v, 8'h00);
    wr(RA, 8'h40);
    wr(RA, 8'h00);
    rd(RA, v); check("R3", "zero write keeps arm", v, 8'h40);
    idle(4);
    wr(RA, 8'h40);
    idle(11);
    rd(RA, v); check("R3", "rewrite restarts hold", v, 8'h40);
    idle(1);
    rd(RA, v); check("R3", "restarted hold ends", v, 8'h00);
  endtask

  task automatic t_trig_flag();
    logic [7:0] v;
    do_reset();
    wr(RB, 8'h40);
    check("R5", "start active", active, 1);
    check("R5", "start count", count, RLD);
    rd(RB, v); check("R4", "trigger set", v, 8'h40);
    idle(11);
    rd(RB, v); check("R4", "trigger at 12th cycle", v, 8'h40);
    idle(1);
    rd(RB, v); check("R4", "trigger cleared", v, 8'h00);
    check("R8", "count after 12", count, RLD - 12);
  endtask

  task automatic t_refresh();
    do_reset();
    wr(RB, 8'h40);
    idle(20);
    check("R8", "count after 20", count, RLD - 20);
    wr(RA, 8'h40);
    wr(RB, 8'h40);
    check("R6", "refresh reload", count, RLD);
    idle(1);
    check("R6", "count after refresh", count, RLD - 1);
  endtask

  task automatic t_no_refresh();
    do_reset();
    wr(RB, 8'h40);
    idle(20);
    wr(RB, 8'h40);
    check("R7", "lone trigger", count, RLD - 21);
    wr(RA, 8'h40);
    wr(8'h55, 8'h00);
    wr(RB, 8'h40);
    check("R7", "other write between", count, RLD - 24);
    wr(RA, 8'h40);
    idle(12);
    wr(RB, 8'h40);
    check("R7", "arm already cleared", count, RLD - 38);
    wr(RA, 8'h40);
    wr(RA, 8'h00);
    wr(RB, 8'h40);
    check("R7", "non-arming A write between", count, RLD - 41);
    check("R7", "still active", active, 1);
  endtask

  task automatic t_expire();
    do_reset();
    wr(RB, 8'h40);
    idle(RLD);
    check("R8", "count zero", count, 0);
    check("R8", "active at zero", active, 1);
    check("R8", "no early request", req, 0);
    idle(1);
    check("R8", "request high", req, 1);
    check("R8", "stopped", active, 0);
    idle(1);
    check("R8", "request one cycle", req, 0);
    check("R8", "stays stopped", active, 0);
    wr(RB, 8'h40);
    check("R5", "restart after expiry", active, 1);
    check("R5", "restart count", count, RLD);
  endtask

  task automatic t_collision();
    do_reset();
    wr(RB, 8'h40);
    idle(RLD - 1);
    wr(RA, 8'h40);
    check("R9", "count zero before trigger", count, 0);
    check("R9", "active before trigger", active, 1);
    wr(RB, 8'h40);
    check("R9", "no request", req, 0);
    check("R9", "still active", active, 1);
    check("R9", "reloaded", count, RLD);
    idle(1);
    check("R9", "no late request", req, 0);
    check("R9", "counting on", count, RLD - 1);
  endtask

  task automatic t_no_stop();
    do_reset();
    wr(RB, 8'h40);
    wr(RA, 8'h00);
    wr(RB, 8'h00);
    check("R10", "active after clears", active, 1);
    check("R10", "counting", count, RLD - 2);
    check("R10", "gie low", gie, 0);
    wr(RA, 8'h80);
    check("R2", "gie set", gie, 1);
    check("R10", "still counting", count, RLD - 3);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_arm_flag();
    t_trig_flag();
    t_refresh();
    t_no_refresh();
    t_expire();
    t_collision();
    t_no_stop();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule